// File: doc/BRIEF.md
# Two-Channel Converter Holding Register and Transfer Controller

This block sits between a register write port and the digital side of a two-channel digital-to-analog converter. Software, or a DMA engine, writes sample values into a holding register per channel. A value can be written to one channel alone or packed with the other channel's value into a single word. Three data formats are accepted: 12-bit right-aligned, 12-bit left-aligned and 8-bit. Each format has its own write address.

Each channel has an output register that drives the converter. When the channel's trigger is off, the output follows the holding register. When the trigger is on, the held value moves to the output only after a selected event occurs. The event can come from one of seven hardware lines or from a software trigger bit that clears itself. After each triggered transfer the channel can pulse a DMA request, so that the holding register is refilled before the next event.

Top module: `dac_hold_ctrl`

## Requirements
- R1: After reset both output registers, both DMA request lines and both software trigger pending bits are zero.
- R2: A write to address 0 (channel A) or address 3 (channel B) loads that channel's holding register from data bits 11:0. All other data bits are ignored.
- R3: A write to address 1 (channel A) or address 4 (channel B) loads that channel's holding register from data bits 15:4.
- R4: A write to address 2 (channel A) or address 5 (channel B) takes the 8-bit value in data bits 7:0. That value goes to holding bits 11:4, and holding bits 3:0 become zero.
- R5: The dual addresses load both channels in one write:
  - address 6 takes channel A from bits 11:0 and channel B from bits 27:16;
  - address 7 takes channel A from bits 15:4 and channel B from bits 31:20;
  - address 8 takes 8-bit values from bits 7:0 (channel A) and bits 15:8 (channel B), each placed as in R4.
- R6: For an enabled channel with its trigger off, the output register takes the holding value on the clock edge after the holding register was written. That is the second rising edge after the write is presented.
- R7: For an enabled channel with its trigger on, the output register does not change until the selected trigger is detected. The transfer happens one clock after detection, which is the second rising edge after a hardware line is seen high.
- R8: Hardware trigger lines are edge-detected. Each low-to-high change on the selected line gives exactly one transfer. A line held high gives no further transfers, and lines that are not selected have no effect.
- R9: Trigger select codes 0 to 6 pick hardware line 0 to 6, and code 7 picks the software trigger. Writing address 9 sets the pending bit of channel A (data bit 0) and of channel B (data bit 1). A pending bit is cleared by hardware on the edge where its transfer happens, three rising edges after the write.
- R10: When DMA is enabled for a channel, each triggered transfer raises that channel's DMA request for exactly one cycle, starting on the same edge as the transfer. When DMA is disabled, no request is raised.
- R11: A channel whose enable bit is clear ignores all triggers, does not follow its holding register and raises no DMA request. Its holding register still accepts writes.
- R12: If a holding write and a triggered transfer fall on the same edge, the output gets the previous holding value. The new value waits for the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address (0-9) |
| wr_data | input | 32 | Register write data |
| ch_en | input | 2 | Channel enable (bit 0 = A, bit 1 = B) |
| trig_en | input | 2 | Trigger-gated transfer enable per channel |
| dma_en | input | 2 | DMA request enable per channel |
| sel_a | input | 3 | Trigger select for channel A |
| sel_b | input | 3 | Trigger select for channel B |
| trig_in_a | input | 7 | Hardware trigger lines for channel A |
| trig_in_b | input | 7 | Hardware trigger lines for channel B |
| dout_a | output | 12 | Channel A output register |
| dout_b | output | 12 | Channel B output register |
| dma_req | output | 2 | DMA request pulse per channel |
| sw_pend | output | 2 | Software trigger pending bits |

## Verification
Two pairs of actions can land in the same cycle.

The first pair is a holding write and a triggered transfer. The bench raises the selected line and writes a new holding value one cycle later, so the holding load and the transfer share an edge. The output must show the older value, and the newer value must appear only after the next rising edge of the line.

The second pair is a software trigger and its own clearing. The bench watches the pending bit over the cycles after it is set and checks that exactly one transfer happens and that the bit drops on the transfer edge, with no repeat once the holding register changes again.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;

    localparam int DAC_W   = 12;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int NUM_CH  = 2;
    localparam int HW_TRIG = 7;
    localparam int SEL_W   = 3;

    typedef logic [DAC_W-1:0] sample_t;

    // Write address map; the bench and software rely on these codes.
    typedef enum logic [ADDR_W-1:0] {
        REG_A_R12  = 4'd0,
        REG_A_L12  = 4'd1,
        REG_A_R8   = 4'd2,
        REG_B_R12  = 4'd3,
        REG_B_L12  = 4'd4,
        REG_B_R8   = 4'd5,
        REG_D_R12  = 4'd6,
        REG_D_L12  = 4'd7,
        REG_D_R8   = 4'd8,
        REG_SWTRIG = 4'd9
    } reg_addr_e;

    // Format converters from a bus lane to a held sample.
    function automatic sample_t fmt_r12(input logic [DAC_W-1:0] lane);
        return lane;
    endfunction

    function automatic sample_t fmt_l12(input logic [15:0] lane);
        return lane[15:4];
    endfunction

    function automatic sample_t fmt_r8(input logic [7:0] lane);
        return {lane, 4'h0};
    endfunction

endpackage

// File: rtl/dac_hold_decode.sv
module dac_hold_decode
    import dac_hold_pkg::*;
(
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BUS_W-1:0]        wr_data,
    output logic [NUM_CH-1:0]       load,
    output sample_t [NUM_CH-1:0]    load_val,
    output logic [NUM_CH-1:0]       sw_set
);

    typedef struct packed {
        logic [NUM_CH-1:0]    load;
        sample_t [NUM_CH-1:0] val;
        logic [NUM_CH-1:0]    sw;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d = '0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_A_R12: begin
                    dec_d.load[0] = 1'b1;
                    dec_d.val[0]  = fmt_r12(wr_data[11:0]);
                end
                REG_A_L12: begin
                    dec_d.load[0] = 1'b1;
                    dec_d.val[0]  = fmt_l12(wr_data[15:0]);
                end
                REG_A_R8: begin
                    dec_d.load[0] = 1'b1;
                    dec_d.val[0]  = fmt_r8(wr_data[7:0]);
                end
                REG_B_R12: begin
                    dec_d.load[1] = 1'b1;
                    dec_d.val[1]  = fmt_r12(wr_data[11:0]);
                end
                REG_B_L12: begin
                    dec_d.load[1] = 1'b1;
                    dec_d.val[1]  = fmt_l12(wr_data[15:0]);
                end
                REG_B_R8: begin
                    dec_d.load[1] = 1'b1;
                    dec_d.val[1]  = fmt_r8(wr_data[7:0]);
                end
                REG_D_R12: begin
                    dec_d.load   = '1;
                    dec_d.val[0] = fmt_r12(wr_data[11:0]);
                    dec_d.val[1] = fmt_r12(wr_data[27:16]);
                end
                REG_D_L12: begin
                    dec_d.load   = '1;
                    dec_d.val[0] = fmt_l12(wr_data[15:0]);
                    dec_d.val[1] = fmt_l12(wr_data[31:16]);
                end
                REG_D_R8: begin
                    dec_d.load   = '1;
                    dec_d.val[0] = fmt_r8(wr_data[7:0]);
                    dec_d.val[1] = fmt_r8(wr_data[15:8]);
                end
                REG_SWTRIG: begin
                    dec_d.sw = wr_data[NUM_CH-1:0];
                end
                default: ;
            endcase
        end
    end

    assign load     = dec_d.load;
    assign load_val = dec_d.val;
    assign sw_set   = dec_d.sw;

endmodule

// File: rtl/dac_trig_detect.sv
module dac_trig_detect #(
    parameter int N_HW = 7,
    parameter int SW_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ch_en,
    input  logic            trig_en,
    input  logic [SW_W-1:0] sel,
    input  logic [N_HW-1:0] trig_in,
    input  logic            sw_set,
    output logic            hit,
    output logic            sw_pend
);

    localparam int SOFT_CODE = N_HW;

    typedef struct packed {
        logic [N_HW-1:0] prev;
        logic            sw;
        logic            hit;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [N_HW-1:0] rise;
    logic            soft_sel;
    logic            det;

    always_comb begin
        rise     = trig_in & ~st_q.prev;
        soft_sel = (int'(sel) == SOFT_CODE);
        det      = 1'b0;
        if (soft_sel) begin
            // A pending software request fires once; the in-flight hit blocks a repeat.
            det = st_q.sw & ~st_q.hit;
        end else if (int'(sel) < N_HW) begin
            det = rise[sel];
        end
        det = det & ch_en & trig_en;

        st_d      = st_q;
        st_d.prev = trig_in;
        st_d.hit  = det;
        st_d.sw   = (st_q.sw & ~(st_q.hit & soft_sel)) | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit     = st_q.hit;
    assign sw_pend = st_q.sw;

    // A pending bit only drops after a detection made while the channel was armed.
    assert_sw_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sw) |-> $past(ch_en && trig_en, 2));

endmodule

// File: rtl/dac_chan_path.sv
module dac_chan_path #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_en,
    input  logic          trig_en,
    input  logic          dma_en,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          hit,
    output logic [DW-1:0] dout,
    output logic          dma_req
);

    typedef struct packed {
        logic [DW-1:0] hold;
        logic [DW-1:0] out;
        logic          dma;
    } path_state_t;

    path_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.dma = 1'b0;
        if (load) st_d.hold = load_val;
        if (ch_en) begin
            if (!trig_en) begin
                st_d.out = st_q.hold;
            end else if (hit) begin
                st_d.out = st_q.hold;
                st_d.dma = dma_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.out;
    assign dma_req = st_q.dma;

    // A disabled channel neither moves its output nor requests data.
    assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ch_en) |-> ($stable(st_q.out) && !st_q.dma));

endmodule

// File: rtl/dac_hold_ctrl.sv
module dac_hold_ctrl
    import dac_hold_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [NUM_CH-1:0]  ch_en,
    input  logic [NUM_CH-1:0]  trig_en,
    input  logic [NUM_CH-1:0]  dma_en,
    input  logic [SEL_W-1:0]   sel_a,
    input  logic [SEL_W-1:0]   sel_b,
    input  logic [HW_TRIG-1:0] trig_in_a,
    input  logic [HW_TRIG-1:0] trig_in_b,
    output logic [DAC_W-1:0]   dout_a,
    output logic [DAC_W-1:0]   dout_b,
    output logic [NUM_CH-1:0]  dma_req,
    output logic [NUM_CH-1:0]  sw_pend
);

    logic [NUM_CH-1:0]                load;
    sample_t [NUM_CH-1:0]             load_val;
    logic [NUM_CH-1:0]                sw_set;
    logic [NUM_CH-1:0]                hit;
    logic [NUM_CH-1:0][SEL_W-1:0]     sel_arr;
    logic [NUM_CH-1:0][HW_TRIG-1:0]   trig_arr;
    logic [NUM_CH-1:0][DAC_W-1:0]     dout_arr;

    assign sel_arr  = {sel_b, sel_a};
    assign trig_arr = {trig_in_b, trig_in_a};

    dac_hold_decode i_decode (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load     (load),
        .load_val (load_val),
        .sw_set   (sw_set)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dac_trig_detect #(.N_HW(HW_TRIG), .SW_W(SEL_W)) i_detect (
            .clk     (clk),
            .rst_n   (rst_n),
            .ch_en   (ch_en[c]),
            .trig_en (trig_en[c]),
            .sel     (sel_arr[c]),
            .trig_in (trig_arr[c]),
            .sw_set  (sw_set[c]),
            .hit     (hit[c]),
            .sw_pend (sw_pend[c])
        );

        dac_chan_path #(.DW(DAC_W)) i_path (
            .clk      (clk),
            .rst_n    (rst_n),
            .ch_en    (ch_en[c]),
            .trig_en  (trig_en[c]),
            .dma_en   (dma_en[c]),
            .load     (load[c]),
            .load_val (load_val[c]),
            .hit      (hit[c]),
            .dout     (dout_arr[c]),
            .dma_req  (dma_req[c])
        );

        // In gated mode the output moves only after a detection.
        assert_gated_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(trig_en[c]) && !$stable(dout_arr[c])) |-> $past(hit[c]));

        // A request needs DMA enabled and an armed trigger two cycles earlier.
        assert_dma_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req[c] |-> ($past(dma_en[c]) && $past(trig_en[c], 2)));
    end

    assign dout_a = dout_arr[0];
    assign dout_b = dout_arr[1];

endmodule

// File: tb/test_dac_hold_ctrl.sv
module test_dac_hold_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  ch_en = '0, trig_en = '0, dma_en = '0;
    logic [2:0]  sel_a = '0, sel_b = '0;
    logic [6:0]  trig_in_a = '0, trig_in_b = '0;
    logic [11:0] dout_a, dout_b;
    logic [1:0]  dma_req, sw_pend;

    int total = 0;
    int failed = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    cyc;
        int    kind;   // 0 output value, 1 DMA request, 2 pending bit
        int    ch;
        int    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_hold_ctrl i_dac_hold_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ch_en(ch_en), .trig_en(trig_en), .dma_en(dma_en), .sel_a(sel_a), .sel_b(sel_b),
        .trig_in_a(trig_in_a), .trig_in_b(trig_in_b), .dout_a(dout_a), .dout_b(dout_b),
        .dma_req(dma_req), .sw_pend(sw_pend)
    );

    task automatic check(input string tag, input int act, input int expv);
        total++;
        if (act !== expv) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int observe(input int kind, input int ch);
        case (kind)
            0:       return ch == 1 ? int'(dout_b) : int'(dout_a);
            1:       return int'(dma_req[ch]);
            default: return int'(sw_pend[ch]);
        endcase
    endfunction

    task automatic expect_at(input int dly, input int kind, input int ch, input int val, input string tag);
        exp_t e;
        e.cyc = cyc + dly; e.kind = kind; e.ch = ch; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pops every item due in this cycle and compares it.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                check(sb[i].tag, observe(sb[i].kind, sb[i].ch), sb[i].val);
                sb.delete(i);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset dout_a", int'(dout_a), 0);
        check("R1 reset dout_b", int'(dout_b), 0);
        check("R1 reset dma_req", int'(dma_req), 0);
        check("R1 reset sw_pend", int'(sw_pend), 0);

        // Follow mode: format decoding and timing.
        ch_en = 2'b11;
        tick();
        expect_at(2, 0, 0, 'h123, "R2 A right12 ignores upper bits");
        wr(4'd0, 32'hFFFF_F123);
        expect_at(2, 0, 0, 'hABC, "R3 A left12");
        wr(4'd1, 32'h0000_ABCD);
        expect_at(2, 0, 0, 'h5A0, "R4 A 8-bit");
        wr(4'd2, 32'h0000_3C5A);
        expect_at(2, 0, 1, 'hFED, "R2 B right12");
        wr(4'd3, 32'h0000_0FED);
        expect_at(2, 0, 1, 'h123, "R3 B left12");
        wr(4'd4, 32'h0000_1230);
        expect_at(2, 0, 1, 'h990, "R4 B 8-bit");
        wr(4'd5, 32'hFFFF_FF99);
        expect_at(2, 0, 0, 'h789, "R5 dual right12 A");
        expect_at(2, 0, 1, 'h456, "R5 dual right12 B");
        wr(4'd6, 32'h0456_0789);
        expect_at(2, 0, 0, 'hDEF, "R5 dual left12 A");
        expect_at(2, 0, 1, 'hABC, "R5 dual left12 B");
        wr(4'd7, 32'hABC0_DEF0);
        expect_at(1, 0, 0, 'hDEF, "R6 output one edge behind holding");
        expect_at(2, 0, 0, 'h120, "R5 dual 8-bit A");
        expect_at(2, 0, 1, 'h340, "R5 dual 8-bit B");
        wr(4'd8, 32'h0000_3412);
        repeat (3) tick();

        // Gated mode on A, hardware line 2, DMA on.
        trig_en = 2'b01; sel_a = 3'd2; dma_en = 2'b01;
        expect_at(2, 0, 0, 'h120, "R7 write alone does not transfer");
        expect_at(4, 0, 0, 'h120, "R7 still held");
        wr(4'd0, 32'h0000_0321);
        repeat (3) tick();
        trig_in_a = 7'b000_1000;
        expect_at(2, 0, 0, 'h120, "R8 unselected line ignored");
        expect_at(2, 1, 0, 0, "R8 no DMA from unselected line");
        tick();
        trig_in_a = '0;
        repeat (2) tick();
        trig_in_a[2] = 1'b1;
        expect_at(1, 0, 0, 'h120, "R7 no transfer in detection cycle");
        expect_at(2, 0, 0, 'h321, "R7 transfer after trigger");
        expect_at(2, 1, 0, 1, "R10 DMA request with transfer");
        expect_at(3, 1, 0, 0, "R10 DMA request lasts one cycle");
        tick();
        expect_at(1, 0, 0, 'h321, "R12 same-edge write keeps old value");
        wr(4'd0, 32'h0000_0111);
        expect_at(4, 0, 0, 'h321, "R8 held level gives no retrigger");
        expect_at(4, 1, 0, 0, "R8 no DMA while level held");
        repeat (5) tick();
        trig_in_a = '0;
        repeat (2) tick();
        trig_in_a[2] = 1'b1;
        expect_at(2, 0, 0, 'h111, "R12 new value on next trigger");
        expect_at(2, 1, 0, 1, "R10 DMA request on second trigger");
        tick();
        trig_in_a = '0;
        repeat (3) tick();

        // Software trigger on B, no DMA for B.
        trig_en = 2'b11; sel_b = 3'd7;
        expect_at(2, 0, 1, 'h340, "R7 B gated after write");
        wr(4'd3, 32'h0000_00AA);
        expect_at(1, 2, 1, 1, "R9 pending set");
        expect_at(2, 2, 1, 1, "R9 pending held until transfer");
        expect_at(2, 0, 1, 'h340, "R9 no early transfer");
        expect_at(3, 0, 1, 'h0AA, "R9 software transfer");
        expect_at(3, 2, 1, 0, "R9 pending self-clears");
        expect_at(3, 1, 1, 0, "R10 no DMA when disabled");
        expect_at(1, 2, 0, 0, "R9 A pending untouched");
        wr(4'd9, 32'h0000_0002);
        repeat (3) tick();
        expect_at(3, 0, 1, 'h0AA, "R9 single transfer per request");
        wr(4'd3, 32'h0000_00BB);
        repeat (3) tick();

        // External line select.
        sel_b = 3'd6;
        tick();
        trig_in_b[6] = 1'b1;
        expect_at(2, 0, 1, 'h0BB, "R9 code 6 selects line 6");
        tick();
        trig_in_b = '0;
        repeat (3) tick();

        // Channel A disabled.
        ch_en = 2'b10;
        tick();
        expect_at(2, 0, 0, 'h111, "R11 write does not reach output");
        wr(4'd0, 32'h0000_0777);
        trig_in_a[2] = 1'b1;
        expect_at(2, 0, 0, 'h111, "R11 trigger ignored");
        expect_at(2, 1, 0, 0, "R11 no DMA when disabled");
        tick();
        trig_in_a = '0;
        trig_en = 2'b10;
        expect_at(3, 0, 0, 'h111, "R11 no follow while disabled");
        repeat (4) tick();
        ch_en = 2'b11;
        expect_at(2, 0, 0, 'h777, "R6 follows after re-enable");
        repeat (3) tick();

        while (sb.size() != 0) tick();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule